// File: doc/BRIEF.md
# Card Clock Divider With Gating

This block derives the card bus clock from the host master clock. A control word, loaded through a simple write port, picks the division ratio. The ratio can be the master clock itself, the master clock halved, or one power of two from 4 to 1024, each chosen by its own one-hot bit. The same word holds an output enable and an auto-stop flag. When auto-stop is set, the card clock is held quiet while the command/data engine reports that the bus is idle.

Every change in the output is made glitch-free. A high phase always runs to its full length. The divider restarts with a complete low phase. A new ratio only takes hold while the clock is stopped. Besides the card clock, the block drives a one-cycle strobe in the master clock domain that marks each card clock rising edge. Logic that runs on the master clock can use this strobe to step in lockstep with the card bus.

There is no data stream through this block. The write port and the idle input are plain control pins with no back-pressure. A write is taken on any master clock edge where the write strobe is high.

Top module: `card_clk_div`

## Requirements
- R1: After reset, and as long as the enable bit (bit 8) of the control word stays clear, `card_clk` is low and `clk_en_pulse` never rises, whatever ratio bits are written.
- R2: Ratio encoding, where N is the master cycles per card clock period:
  - bit i for i in 0..7 gives N = 2^(i+2);
  - bit 16 gives N = 1024 when the 1024 option is built in;
  - bit 10 gives N = 1, where the card clock follows the master clock;
  - no ratio bit set gives N = 2.
- R3: When several ratio bits are set, the one at the highest bit position wins. The order is bit 16, then bit 10, then bits 7 down to 0.
- R4: For N of 2 or more, the high and low phases of `card_clk` each last N/2 master cycles.
- R5: A write that sets the enable bit while the clock is stopped gives the first card clock rising edge max(1, N/2) master edges after the write edge. That first low phase is complete.
- R6: Clearing the enable bit during a high phase lets that phase finish at its full length. The output then stays low and no strobe is produced.
- R7: A ratio written while the clock runs does not change the period. It takes effect once the clock has stopped, or when it is written together with the enable bit from the stopped state.
- R8: With auto-stop (bit 9) set and `bus_idle` high, the current high phase completes. The clock then parks low and no strobe is produced.
- R9: With auto-stop set, once the clock is parked by idle for at least a full low phase, it rises on the first master edge after `bus_idle` falls. This holds in every ratio, including N = 1.
- R10: With auto-stop clear, `bus_idle` has no effect on the period.
- R11: `clk_en_pulse` is high for exactly the one master cycle that starts at each card clock rising edge. In N = 1 mode it stays high while the clock runs.
- R12: Bits 11 to 15 of the control word are reserved and have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_we | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 17 | Control word: ratio bits, enable (8), auto-stop (9), divide-by-1 (10), divide-by-1024 (16) |
| bus_idle | input | 1 | High while the command/data engine has no bus activity |
| card_clk | output | 1 | Card bus clock |
| clk_en_pulse | output | 1 | One master cycle strobe at each card clock rising edge |

## Verification
The bench goes after several corner cases, and each one shows a distinct fault if the design gets it wrong:
- Decoding: every ratio code, including the all-zero code, and mixed-bit words that test the priority order. A decoder with the wrong order gives a wrong period.
- Disable: the enable bit cleared just after a rising edge. A design that parks immediately leaves a runt high phase that the bench counts as too short.
- Ratio change: a ratio rewritten mid-run. A design that applies it at once changes the period before the clock has stopped.
- Auto-stop: idle asserted and released in divided and undivided modes. A design that does not wait for the high phase, or that adds a fresh low phase on resume, misses the expected edge.

// File: rtl/cdiv_pkg.sv
`timescale 1ns/100ps
package cdiv_pkg;
  localparam int unsigned WORD_W       = 17;
  localparam int unsigned POW_BITS     = 8;
  localparam int unsigned POW_BASE_LOG = 2;
  localparam int unsigned TOP_LOG      = 10;
  localparam int unsigned F_RUN        = 8;
  localparam int unsigned F_AUTO       = 9;
  localparam int unsigned F_BYP        = 10;
  localparam int unsigned F_RSV_LO     = 11;
  localparam int unsigned F_RSV_HI     = 15;
  localparam int unsigned F_TOP        = 16;
  localparam int unsigned LOG_W        = $clog2(TOP_LOG + 1);

  typedef logic [LOG_W-1:0] ratio_log_t;

  typedef struct packed {
    logic                top;
    logic                byp;
    logic                autostop;
    logic                run;
    logic [POW_BITS-1:0] pow;
  } ctl_t;
endpackage

// File: rtl/cdiv_ratio_sel.sv
`timescale 1ns/100ps
module cdiv_ratio_sel
  import cdiv_pkg::*;
#(
  parameter bit HAS_TOP_DIV = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  ctl_t       cand,
  input  logic       park,
  output ratio_log_t ratio_log
);
  logic       top_sel;
  ratio_log_t dec;

  generate
    if (HAS_TOP_DIV) begin : g_top
      assign top_sel = cand.top;
    end else begin : g_no_top
      logic unused_top;
      assign unused_top = cand.top;
      assign top_sel    = 1'b0;
    end
  endgenerate

  logic unused_flags;
  assign unused_flags = cand.run ^ cand.autostop;

  // Priority follows bit position: top bit, then bypass bit, then pow[7..0].
  always_comb begin
    dec = ratio_log_t'(1);
    for (int i = 0; i < POW_BITS; i++) begin
      if (cand.pow[i]) dec = ratio_log_t'(i + POW_BASE_LOG);
    end
    if (cand.byp) dec = '0;
    if (top_sel)  dec = ratio_log_t'(TOP_LOG);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ratio_log <= ratio_log_t'(1);
    else if (park) ratio_log <= dec;
  end

  p_ratio_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_log <= ratio_log_t'(TOP_LOG));

  p_ratio_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(park) |-> $stable(ratio_log));
endmodule

// File: rtl/cdiv_counter.sv
`timescale 1ns/100ps
module cdiv_counter #(
  parameter int unsigned CNT_W = 9,
  parameter int unsigned LOG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LOG_W-1:0] ratio_log,
  input  logic             run_en,
  input  logic             run_ok,
  output logic             div_q,
  output logic             rise_q
);
  localparam int unsigned FULL_W = CNT_W + 1;

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  half_m1;
  logic [FULL_W-1:0] half_full;
  logic              at_end;
  logic              bypass;

  always_comb begin
    bypass    = (ratio_log == '0);
    half_full = '0;
    if (!bypass) half_full = FULL_W'(1) << (ratio_log - 1'b1);
    half_m1   = CNT_W'(half_full - FULL_W'(1));
    at_end    = (cnt == half_m1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= 1'b0;
      cnt    <= '0;
      rise_q <= 1'b0;
    end else begin
      rise_q <= 1'b0;
      if (bypass) begin
        div_q <= 1'b0;
        cnt   <= '0;
      end else if (div_q) begin
        // High phase always runs to completion.
        if (at_end) begin
          div_q <= 1'b0;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (!run_en) begin
        cnt <= '0;
      end else if (at_end) begin
        // Low phase served; rise only when not held by idle.
        if (run_ok) begin
          div_q  <= 1'b1;
          cnt    <= '0;
          rise_q <= 1'b1;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= half_m1);

  p_rise_marks_edge_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rise_q |-> (div_q && !$past(div_q)));

  p_rise_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rise_q |=> !rise_q);
endmodule

// File: rtl/cdiv_bypass_gate.sv
`timescale 1ns/100ps
module cdiv_bypass_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  output logic gate_q,
  output logic bclk
);
  // Gate updates on the falling edge, so it only moves while clk is low.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= want;
  end

  assign bclk = clk & gate_q;

  p_gate_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(want) && !want |-> !gate_q);
endmodule

// File: rtl/card_clk_div.sv
`timescale 1ns/100ps
module card_clk_div
  import cdiv_pkg::*;
#(
  parameter bit HAS_TOP_DIV = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [WORD_W-1:0] ctl_wdata,
  input  logic              bus_idle,
  output logic              card_clk,
  output logic              clk_en_pulse
);
  localparam int unsigned CNT_W = TOP_LOG - 1;

  ctl_t       wr_word;
  ctl_t       ctl_q;
  ctl_t       cand;
  ratio_log_t ratio_log;
  logic       div_q;
  logic       rise_q;
  logic       gate_q;
  logic       bclk;
  logic       byp_pulse_q;
  logic       park;
  logic       run_ok;
  logic       want_byp;

  logic unused_rsvd;
  assign unused_rsvd = ^ctl_wdata[F_RSV_HI:F_RSV_LO];

  always_comb begin
    wr_word.pow      = ctl_wdata[POW_BITS-1:0];
    wr_word.run      = ctl_wdata[F_RUN];
    wr_word.autostop = ctl_wdata[F_AUTO];
    wr_word.byp      = ctl_wdata[F_BYP];
    wr_word.top      = ctl_wdata[F_TOP];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_we) ctl_q <= wr_word;
  end

  assign park     = !ctl_q.run && !div_q && !gate_q;
  assign cand     = ctl_we ? wr_word : ctl_q;
  assign run_ok   = ctl_q.run && !(ctl_q.autostop && bus_idle);
  assign want_byp = (ratio_log == '0) && run_ok;

  cdiv_ratio_sel #(.HAS_TOP_DIV(HAS_TOP_DIV)) u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .cand      (cand),
    .park      (park),
    .ratio_log (ratio_log)
  );

  cdiv_counter #(.CNT_W(CNT_W), .LOG_W(LOG_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .ratio_log (ratio_log),
    .run_en    (ctl_q.run),
    .run_ok    (run_ok),
    .div_q     (div_q),
    .rise_q    (rise_q)
  );

  cdiv_bypass_gate u_byp (
    .clk    (clk),
    .rst_n  (rst_n),
    .want   (want_byp),
    .gate_q (gate_q),
    .bclk   (bclk)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) byp_pulse_q <= 1'b0;
    else        byp_pulse_q <= gate_q;
  end

  // At most one path is active, so OR-ing the two sources cannot glitch.
  assign card_clk     = bclk | div_q;
  assign clk_en_pulse = rise_q | byp_pulse_q;

  p_pulse_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_q, byp_pulse_q}));

  p_off_no_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q.run && !div_q) |=> !rise_q);

  p_idle_park_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.run && ctl_q.autostop && bus_idle && !div_q) |=> !div_q);
endmodule

// File: tb/tb_card_clk_div.sv
`timescale 1ns/100ps
module tb_card_clk_div;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [16:0] ctl_wdata = '0;
  logic        bus_idle = 1'b0;
  logic        card_clk;
  logic        clk_en_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit cc;
  bit pl;

  always #2.5 clk = ~clk;

  card_clk_div dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctl_we       (ctl_we),
    .ctl_wdata    (ctl_wdata),
    .bus_idle     (bus_idle),
    .card_clk     (card_clk),
    .clk_en_pulse (clk_en_pulse)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    cc = card_clk;
    pl = clk_en_pulse;
  endtask

  function automatic logic [16:0] wd(input bit run, input bit au, input bit byp,
                                     input bit top, input logic [7:0] pow);
    return {top, 5'b00000, byp, au, run, pow};
  endfunction

  function automatic int exp_log(input logic [16:0] w);
    int k = 1;
    for (int i = 0; i < 8; i++) if (w[i]) k = i + 2;
    if (w[10]) k = 0;
    if (w[16]) k = 10;
    return k;
  endfunction

  function automatic int exp_half(input int k);
    return (k == 0) ? 1 : (1 << (k - 1));
  endfunction

  function automatic int exp_period(input int k);
    return (k == 0) ? 1 : (1 << k);
  endfunction

  task automatic wr(input logic [16:0] w);
    ctl_wdata = w;
    ctl_we = 1'b1;
    tick();
    ctl_we = 1'b0;
  endtask

  task automatic wait_pulse(output int n);
    n = 0;
    do begin
      tick();
      n++;
    end while (!pl && n < 2100);
  endtask

  task automatic measure(input string req, input int k);
    int per = 0;
    int hi = cc;
    do begin
      tick();
      per++;
      if (!pl) hi += cc;
    end while (!pl && per < 3000);
    chk({req, " R2 period"}, per, exp_period(k));
    chk({req, " R4/R11 high samples"}, hi, exp_half(k));
  endtask

  task automatic stop_settle(input logic [16:0] w);
    wr(w & ~17'h00100);
    repeat (600) tick();
  endtask

  task automatic run_case(input string req, input logic [16:0] w);
    int n;
    int k = exp_log(w);
    wr(w);
    wait_pulse(n);
    chk({req, " R5 first edge latency"}, n, exp_half(k));
    measure(req, k);
    stop_settle(w);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    int hi;
    int plc;
    logic [16:0] w;
    void'($urandom(32'h0C1D5EED));
    repeat (3) tick();
    chk("R1 reset card_clk", card_clk, 0);
    chk("R1 reset pulse", clk_en_pulse, 0);
    rst_n = 1'b1;
    wr(wd(0, 0, 0, 0, 8'h04));
    plc = 0; hi = 0;
    repeat (40) begin tick(); plc += pl; hi += cc; end
    chk("R1 disabled pulses", plc, 0);
    chk("R1 disabled high samples", hi, 0);

    // R2: every ratio code in isolation
    run_case("R2 zero code", wd(1, 0, 0, 0, 8'h00));
    run_case("R2 bypass", wd(1, 0, 1, 0, 8'h00));
    for (int i = 0; i < 8; i++) run_case("R2 pow bit", wd(1, 0, 0, 0, 8'(1 << i)));
    run_case("R2 top bit", wd(1, 0, 0, 1, 8'h00));

    // R3: priority
    run_case("R3 bits5+2", wd(1, 0, 0, 0, 8'h24));
    run_case("R3 bypass over pow", wd(1, 0, 1, 0, 8'h08));
    run_case("R3 top over all", wd(1, 0, 1, 1, 8'h01));

    // R12: reserved bits ignored
    run_case("R12 reserved", wd(1, 0, 0, 0, 8'h02) | 17'h0F800);

    // R6: disable right after a rising edge of a /8 clock
    wr(wd(1, 0, 0, 0, 8'h02));
    wait_pulse(n);
    wr(wd(0, 0, 0, 0, 8'h02));
    hi = cc; plc = pl;
    repeat (30) begin tick(); hi += cc; plc += pl; end
    chk("R6 remaining high samples", hi, 3);
    chk("R6 pulses after disable", plc, 0);
    chk("R6 parked low", cc, 0);
    repeat (10) tick();

    // R7: ratio change while running is deferred
    wr(wd(1, 0, 0, 0, 8'h01));
    wait_pulse(n);
    wr(wd(1, 0, 0, 0, 8'h04));
    wait_pulse(n);
    chk("R7 next edge keeps old ratio", n, 3);
    measure("R7 old ratio kept", 2);
    stop_settle(wd(0, 0, 0, 0, 8'h04));
    run_case("R7 applied after stop", wd(1, 0, 0, 0, 8'h04));

    // R8/R9: auto-stop on /4
    wr(wd(1, 1, 0, 0, 8'h01));
    wait_pulse(n);
    bus_idle = 1'b1;
    hi = 0; plc = 0;
    repeat (20) begin tick(); hi += cc; plc += pl; end
    chk("R8 high finishes", hi, 1);
    chk("R8 no pulses while idle", plc, 0);
    bus_idle = 1'b0;
    tick();
    chk("R9 resume pulse", pl, 1);
    chk("R9 resume high", cc, 1);
    stop_settle(wd(0, 1, 0, 0, 8'h01));

    // R8/R9: auto-stop in divide-by-1
    wr(wd(1, 1, 1, 0, 8'h00));
    wait_pulse(n);
    bus_idle = 1'b1;
    hi = 0; plc = 0;
    repeat (10) begin tick(); hi += cc; plc += pl; end
    chk("R8 bypass parked high", hi, 0);
    chk("R8 bypass parked pulses", plc, 0);
    bus_idle = 1'b0;
    tick();
    chk("R9 bypass resume pulse", pl, 1);
    chk("R9 bypass resume high", cc, 1);
    stop_settle(wd(0, 1, 1, 0, 8'h00));

    // R10: idle ignored without auto-stop
    bus_idle = 1'b1;
    run_case("R10 idle ignored", wd(1, 0, 0, 0, 8'h02));
    bus_idle = 1'b0;

    // Random words
    for (int t = 0; t < 14; t++) begin
      w = wd(1, 0, ($urandom % 5) == 0, ($urandom % 6) == 0,
             8'($urandom & $urandom & $urandom));
      w[15:11] = 5'($urandom);
      run_case("R3 random word", w);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule